// File: doc/BRIEF.md
# Oscillator Trim Register Serial Slave

This block is the write-only slave end of a two-wire serial bus (SCL clock line, open-drain SDA data line). A host uses it to load one 8-bit trim code that sets the load capacitance of a crystal oscillator. A larger code adds capacitance and therefore lowers the crystal frequency. The block samples both bus lines with a much faster system clock, cleans them up and finds edges. It recognises start and stop conditions, checks a fixed 7-bit device address, takes a register address, and then writes each following data byte through an auto-incrementing pointer.

Only pointer value 0x13 is a real register. Bytes sent to any other pointer value are acknowledged and then dropped. The slave acknowledges each byte it accepts by pulling SDA low for the ninth clock. The open-drain driver itself lies outside the block: `sda_oe` high means "pull the line low", and `sda_oe` low means the line is released.

Top module: `xo_trim_slave`

## Requirements
- R1: After reset `trim_o` is 0x80 and `sda_oe` is 0 (SDA released).
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Bus activity outside a start-to-stop frame is ignored and never acknowledged.
- R3: A first byte of 0xD2 (address 1101001 sent MSB first, then R/W = 0) is acknowledged. `sda_oe` rises only while SCL is low, holds through the ninth clock, and is released after that clock's falling edge.
- R4: If the address differs or the R/W bit is 1, no ACK is given, and every later byte up to the next start or stop is neither acknowledged nor written.
- R5: The second byte sets the pointer. A data byte written while the pointer is 0x13 replaces `trim_o`, and any value from 0x00 to 0xFF is accepted.
- R6: The pointer advances by one after each data byte. Bytes written at pointer values other than 0x13 are acknowledged and have no effect on `trim_o`.
- R7: The pointer wraps from 0xFF to 0x00.
- R8: A repeated start (a start with no stop before it) drops the current transfer and begins a new address phase.
- R9: `trim_o` changes only once a full data byte has been received, at the moment that byte's ACK begins. A byte cut short by a stop or a start leaves it unchanged.
- R10: A pulse on SCL that lasts one system clock is filtered out and does not count as a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| trim_o | output | 8 | Oscillator trim code |

## Verification
The assertions assume that the host changes SDA only while SCL is low, except for start and stop conditions. They also assume that every SCL high and low phase lasts well over the few system clocks of synchronizer and filter delay, so the ACK drive can only begin after the filtered falling edge. The stimulus holds each quarter of a bit for ten system clocks and releases SDA during every ninth clock. Its single deliberate glitch is one system clock long, placed while SCL is low, and so stays within what the filter is built to reject.

// File: rtl/xts_pkg.sv
package xts_pkg;

    localparam int          BYTE_W     = 8;
    localparam logic [6:0]  DEV_ADDR   = 7'b1101001;
    localparam logic [7:0]  TRIM_ADDR  = 8'h13;
    localparam logic [7:0]  TRIM_RESET = 8'h80;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_REGADDR,
        ST_DATA,
        ST_IGNORE
    } xts_state_e;

    // Bus events, one system clock wide, derived from the filtered lines.
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } xts_cond_t;

    function automatic logic is_write_to_us(input logic [BYTE_W-1:0] b);
        return b == {DEV_ADDR, 1'b0};
    endfunction

endpackage

// File: rtl/xts_line_filter.sv
module xts_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int TAPS        = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);
    localparam int HALF = TAPS / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [TAPS-1:0]        hist_q;
    logic                   filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            hist_q <= '1;
            filt_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            hist_q <= {hist_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
            filt_q <= ($countones(hist_q) > HALF);
        end
    end

    assign line_o = filt_q;
endmodule

// File: rtl/xts_cond_detect.sv
module xts_cond_detect
    import xts_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_f,
    input  logic      sda_f,
    output xts_cond_t cond
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        cond.start = scl_q & scl_f & sda_q & ~sda_f;
        cond.stop  = scl_q & scl_f & ~sda_q & sda_f;
        cond.rise  = ~scl_q & scl_f;
        cond.fall  = scl_q & ~scl_f;
        cond.sda   = sda_f;
    end
endmodule

// File: rtl/xts_byte_engine.sv
module xts_byte_engine
    import xts_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  xts_cond_t         cond,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] trim_o
);
    localparam int               CNT_W    = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    xts_state_e        state;
    logic [BYTE_W-1:0] shift_q;
    logic [BYTE_W-1:0] ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              byte_full;
    logic              ack_phase;
    logic              active;

    assign active = (state == ST_DEVADDR) || (state == ST_REGADDR) || (state == ST_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            shift_q   <= '0;
            ptr_q     <= '0;
            cnt_q     <= '0;
            byte_full <= 1'b0;
            ack_phase <= 1'b0;
            sda_oe    <= 1'b0;
            trim_o    <= TRIM_RESET;
        end else if (cond.start || cond.stop) begin
            state     <= cond.start ? ST_DEVADDR : ST_IDLE;
            cnt_q     <= '0;
            byte_full <= 1'b0;
            ack_phase <= 1'b0;
            sda_oe    <= 1'b0;
        end else if (cond.rise) begin
            if (active && !ack_phase && !byte_full) begin
                shift_q <= {shift_q[BYTE_W-2:0], cond.sda};
                if (cnt_q == CNT_LAST) begin
                    cnt_q     <= '0;
                    byte_full <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end else if (cond.fall) begin
            if (ack_phase) begin
                ack_phase <= 1'b0;
                sda_oe    <= 1'b0;
            end else if (byte_full) begin
                byte_full <= 1'b0;
                case (state)
                    ST_DEVADDR: begin
                        if (is_write_to_us(shift_q)) begin
                            state     <= ST_REGADDR;
                            ack_phase <= 1'b1;
                            sda_oe    <= 1'b1;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                    ST_REGADDR: begin
                        ptr_q     <= shift_q;
                        state     <= ST_DATA;
                        ack_phase <= 1'b1;
                        sda_oe    <= 1'b1;
                    end
                    ST_DATA: begin
                        if (ptr_q == TRIM_ADDR) trim_o <= shift_q;
                        ptr_q     <= ptr_q + 1'b1;
                        ack_phase <= 1'b1;
                        sda_oe    <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/xo_trim_slave.sv
module xo_trim_slave
    import xts_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_TAPS   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] trim_o
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] line_raw, line_filt;
    logic               scl_f, sda_f;
    xts_cond_t          cond;

    assign line_raw = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_filt
        xts_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .TAPS       (FILT_TAPS)
        ) u_filt (
            .clk   (clk),
            .rst   (rst),
            .line_i(line_raw[g]),
            .line_o(line_filt[g])
        );
    end

    assign scl_f = line_filt[0];
    assign sda_f = line_filt[1];

    xts_cond_detect u_det (
        .clk  (clk),
        .rst  (rst),
        .scl_f(scl_f),
        .sda_f(sda_f),
        .cond (cond)
    );

    xts_byte_engine u_eng (
        .clk   (clk),
        .rst   (rst),
        .cond  (cond),
        .sda_oe(sda_oe),
        .trim_o(trim_o)
    );
endmodule

// File: rtl/xts_checker.sv
module xts_checker
    import xts_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_f,
    input xts_cond_t         cond,
    input logic              sda_oe,
    input logic [BYTE_W-1:0] trim_o
);
    logic rst_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            p_reset_state_r1: assert (trim_o == TRIM_RESET && !sda_oe)
                else $error("reset state wrong");
        end
    end

    p_ack_in_low_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_f);

    p_stop_release_r2: assert property (@(posedge clk) disable iff (rst)
        cond.stop |=> !sda_oe);

    p_restart_release_r8: assert property (@(posedge clk) disable iff (rst)
        cond.start |=> !sda_oe);

    p_trim_at_ack_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(trim_o) |-> $rose(sda_oe));
endmodule

bind xo_trim_slave xts_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .scl_f (scl_f),
    .cond  (cond),
    .sda_oe(sda_oe),
    .trim_o(trim_o)
);

// File: tb/tb_xo_trim_slave.sv
module tb_xo_trim_slave;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [7:0] trim_o;
    logic       sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    xo_trim_slave dut (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_m),
        .sda_i (sda_bus),
        .sda_oe(sda_oe),
        .trim_o(trim_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int         checks = 0;
    int         fails  = 0;
    logic [7:0] exp_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wq();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq(); wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        bit acked;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        acked = !sda_bus;
        wq();
        scl_m = 1'b0; wq();
        check(acked == exp_ack, req, "ack on ninth clock", int'(acked), int'(exp_ack));
    endtask

    // Scoreboard monitor: every trim change must match the next queued item.
    initial begin
        logic [7:0] last;
        last = 8'h80;
        forever begin
            @(negedge clk);
            if (!rst && trim_o !== last) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected trim update", int'(trim_o), int'(last));
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(trim_o == e, "R5", "trim update", int'(trim_o), int'(e));
                end
                last = trim_o;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        // R1 reset state
        check(trim_o == 8'h80, "R1", "trim after reset", int'(trim_o), 'h80);
        check(sda_oe == 1'b0, "R1", "sda released after reset", int'(sda_oe), 0);

        // R2: a byte with no start frame is ignored
        send_byte(8'hD2, 1'b0, "R2");
        bus_stop();

        // R3/R5: plain write to the trim register
        bus_start();
        send_byte(8'hD2, 1'b1, "R3");
        send_byte(8'h13, 1'b1, "R3");
        exp_q.push_back(8'hA5);
        send_byte(8'hA5, 1'b1, "R5");
        bus_stop();
        check(sda_oe == 1'b0, "R3", "sda released after frame", int'(sda_oe), 0);

        // R5 range ends
        bus_start();
        send_byte(8'hD2, 1'b1, "R5");
        send_byte(8'h13, 1'b1, "R5");
        exp_q.push_back(8'h00);
        send_byte(8'h00, 1'b1, "R5");
        bus_stop();
        bus_start();
        send_byte(8'hD2, 1'b1, "R5");
        send_byte(8'h13, 1'b1, "R5");
        exp_q.push_back(8'hFF);
        send_byte(8'hFF, 1'b1, "R5");
        bus_stop();

        // R4: wrong address, then read bit set
        bus_start();
        send_byte(8'hD0, 1'b0, "R4");
        send_byte(8'h13, 1'b0, "R4");
        send_byte(8'h44, 1'b0, "R4");
        bus_stop();
        bus_start();
        send_byte(8'hD3, 1'b0, "R4");
        send_byte(8'h13, 1'b0, "R4");
        send_byte(8'h45, 1'b0, "R4");
        bus_stop();
        check(trim_o == 8'hFF, "R4", "trim after refused frames", int'(trim_o), 'hFF);

        // R6: burst from 0x12
        bus_start();
        send_byte(8'hD2, 1'b1, "R6");
        send_byte(8'h12, 1'b1, "R6");
        send_byte(8'h11, 1'b1, "R6");
        exp_q.push_back(8'h22);
        send_byte(8'h22, 1'b1, "R6");
        send_byte(8'h33, 1'b1, "R6");
        bus_stop();
        check(trim_o == 8'h22, "R6", "trim after burst", int'(trim_o), 'h22);

        // R7: pointer wraps from 0xFF; index 20 lands on 0x13
        bus_start();
        send_byte(8'hD2, 1'b1, "R7");
        send_byte(8'hFF, 1'b1, "R7");
        for (int i = 0; i < 21; i++) begin
            if (i == 20) exp_q.push_back(8'h5A);
            send_byte((i == 20) ? 8'h5A : 8'(8'h30 + i), 1'b1, "R7");
        end
        bus_stop();
        check(trim_o == 8'h5A, "R7", "trim after wrap", int'(trim_o), 'h5A);

        // R8: repeated start in the middle of a data byte
        bus_start();
        send_byte(8'hD2, 1'b1, "R8");
        send_byte(8'h13, 1'b1, "R8");
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        send_byte(8'hD2, 1'b1, "R8");
        send_byte(8'h13, 1'b1, "R8");
        exp_q.push_back(8'h77);
        send_byte(8'h77, 1'b1, "R8");
        bus_stop();
        check(trim_o == 8'h77, "R8", "trim after restart", int'(trim_o), 'h77);

        // R9: stop in the middle of a data byte
        bus_start();
        send_byte(8'hD2, 1'b1, "R9");
        send_byte(8'h13, 1'b1, "R9");
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        bus_stop();
        check(trim_o == 8'h77, "R9", "trim after partial byte", int'(trim_o), 'h77);

        // R10: one-clock SCL glitch while SCL is low
        bus_start();
        send_byte(8'hD2, 1'b1, "R10");
        send_byte(8'h13, 1'b1, "R10");
        scl_m = 1'b1;
        @(negedge clk);
        scl_m = 1'b0;
        wq();
        exp_q.push_back(8'h3C);
        send_byte(8'h3C, 1'b1, "R10");
        bus_stop();
        check(trim_o == 8'h3C, "R10", "trim after glitch", int'(trim_o), 'h3C);

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R5", "all expected updates seen", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule